// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sync Hunt

This block turns a serial bit stream into bytes held in a one-entry receive buffer. It runs in two framings. In start/stop framing, a low start bit opens a character and a stop bit closes it. In byte-synchronous framing, the block first hunts bit by bit for a programmed sync pattern and then cuts the stream into back-to-back words. Bits are taken either once per clock or with sixteen clocks per bit. In the sixteen-clock case a glitch filter, a false-start check and a phase counter place the sample point near the middle of each bit, and the phase counter realigns on every data edge.

The held word leaves through a valid/ready pair. `rd_valid` stays high until a cycle with `rd_ready` high takes the word. While the word is not taken, it is never replaced. A word that completes in that time is lost and is reported as an overrun. The error flags are captured together with each word and stay fixed until the next word is captured. A plain `dma_ready` line tells a transfer engine when a clean word is waiting.

Top module: `serial_rx_core`

## Requirements
- R1: `cfg_wlen` sets the data bits per word: 0 gives 8, 1 gives 7, 2 gives 6 and 3 gives 5. Start, stop and parity bits are not counted. The first bit received is `rd_data[0]`, and the unused upper bits read 0.
- R2: With `cfg_x16`=0, `rx_in` is sampled once on each rising `clk`. In start/stop framing, a character opens on the first low sample seen while idle.
- R3: With `cfg_x16`=1, a level change counts only after 3 consecutive rising edges at the new level. A falling edge opens a character only if no counted rise follows within 8 edges. A shorter low pulse produces no word and leaves the receiver idle.
- R4: With `cfg_x16`=1, each bit is taken 8 edges after the last counted transition. A counted transition from phase 4 onward restarts the phase at 0, so a stream with frequent transitions whose bits are 15 clocks long is still received correctly.
- R5: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 checks for even parity and 0 checks for odd parity. `st_parity` is written again at every buffer load.
- R6: `cfg_fmt` value 0 selects synchronous framing. Any other value selects start/stop framing, and only the first stop bit is checked. A low stop bit after nonzero data sets `st_frame`. A low stop bit after all-zero data sets `st_break`. `st_break` stays set until a high line level has been seen and `stat_rd` has been pulsed.
- R7: A loaded word sets `rd_valid` and pulses `full_stb`. A cycle with `rd_valid` and `rd_ready` both high clears the buffer. Data and flags do not change while the word waits.
- R8: A word that completes while the buffer is full is dropped. `st_overrun` rises in the cycle after the held word is taken, and `err_stb` pulses then. Words are dropped until `stat_rd` is pulsed. A load with a parity, frame or break condition also pulses `err_stb`.
- R9: `dma_ready` is high when a word is held that has neither a parity error nor a frame error.
- R10: In synchronous framing, `st_found` is 0 while hunting. A match of the last received bits against `cfg_sync_char` sets `st_found`, pulses `err_stb`, and starts word framing with the next bit. The matched bits are not buffered.
- R11: With `cfg_strip`=1 in synchronous framing, a word equal to the sync pattern is discarded and does not set `rd_valid`.
- R12: `st_match` shows, in synchronous framing, whether the last word equalled the sync pattern. In start/stop framing it shows that a character is in progress.
- R13: `rx_en`=0 stops reception at once and clears `rd_valid`, every flag and `st_found`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receiver enable |
| rx_in | input | 1 | Serial data in |
| cfg_wlen | input | 2 | Word length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_fmt | input | 2 | 0 = synchronous, other values = start/stop |
| cfg_x16 | input | 1 | 1 = sixteen clocks per bit |
| cfg_sync_char | input | 8 | Sync pattern |
| cfg_strip | input | 1 | Discard received sync words |
| rd_valid | output | 1 | Buffer holds a word |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 8 | Buffered word |
| stat_rd | input | 1 | Status-read pulse |
| st_overrun | output | 1 | Overrun flag |
| st_parity | output | 1 | Parity error flag |
| st_frame | output | 1 | Frame error flag |
| st_break | output | 1 | Break flag |
| st_found | output | 1 | Sync found |
| st_match | output | 1 | Sync match or character in progress |
| full_stb | output | 1 | Pulse on buffer load |
| err_stb | output | 1 | Pulse on error, revealed overrun or sync hit |
| dma_ready | output | 1 | Clean word waiting |

## Verification
The hardest case to reach is the delayed overrun. A second word must complete while the first is still held. The flag must stay hidden until the held word is taken, and the receiver must then drop a further word until the status read. The stimulus sends two back-to-back characters without asserting `rd_ready`, takes the first, sends a third and checks that it is dropped, and then pulses `stat_rd`. Sixteen-clock realignment is reached by sending alternating bits 15 clocks long, where a fixed sample point would drift out of the bit. The false-start check uses low pulses of 5 clocks and of 2 clocks.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int DATA_W = 8;
  typedef enum logic [2:0] {FR_HUNT, FR_SEARCH, FR_DATA, FR_PAR, FR_STOP} fr_state_t;

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] wl);
    return {DATA_W{1'b1}} >> wl;
  endfunction
endpackage

// File: rtl/rxs_sampler.sv
module rxs_sampler #(
  parameter int HALF = 8,
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic os16,
  input  logic hunt,
  input  logic sin,
  output logic bit_stb,
  output logic bit_val,
  output logic start_stb,
  output logic lvl
);
  localparam int PH_W  = $clog2(2 * HALF);
  localparam int RUN_W = $clog2(FILT);
  localparam logic [PH_W-1:0]  SAMPLE_PH = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0]  GUARD_PH  = PH_W'(HALF / 2);
  localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(FILT - 1);

  logic             filt, chk;
  logic [RUN_W-1:0] run;
  logic [PH_W-1:0]  ph;
  logic             differ, fire, rise, fall, seeking;

  assign differ  = sin ^ filt;
  assign fire    = differ && (run == RUN_LAST);
  assign rise    = fire & sin;
  assign fall    = fire & ~sin;
  assign seeking = hunt & ~start_stb & ~chk;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      filt <= 1'b1; run <= '0; ph <= '0; chk <= 1'b0;
      bit_stb <= 1'b0; bit_val <= 1'b1; start_stb <= 1'b0; lvl <= 1'b1;
    end else begin
      bit_stb   <= 1'b0;
      start_stb <= 1'b0;
      if (!os16) begin
        filt <= sin; lvl <= sin; run <= '0; ph <= '0; chk <= 1'b0;
        if (seeking) start_stb <= ~sin;
        else begin
          bit_stb <= 1'b1;
          bit_val <= sin;
        end
      end else begin
        run <= (differ && !fire) ? run + 1'b1 : '0;
        if (fire) filt <= sin;
        lvl <= fire ? sin : filt;
        if (seeking) begin
          ph <= '0;
          if (fall) chk <= 1'b1;
        end else if (chk) begin
          if (rise) chk <= 1'b0;
          else if (ph == SAMPLE_PH) begin
            chk <= 1'b0; start_stb <= 1'b1; ph <= ph + 1'b1;
          end else ph <= ph + 1'b1;
        end else if (fire && ph >= GUARD_PH) begin
          ph <= '0;
        end else begin
          ph <= ph + 1'b1;
          if (ph == SAMPLE_PH) begin
            bit_stb <= 1'b1;
            bit_val <= filt;
          end
        end
      end
    end
  end

  // R4: oversampled bits are spaced apart, never on adjacent edges
  assert_x16_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (os16 && bit_stb) |=> !bit_stb);
  // R2: one low sample opens exactly one character
  assert_single_start_R2: assert property (@(posedge clk) disable iff (!rst_n || !en)
    start_stb |=> !start_stb);
endmodule

// File: rtl/rxs_framer.sv
module rxs_framer
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fmt_sync,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [DATA_W-1:0] sync_char,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              start_stb,
  output logic              hunt,
  output logic              busy,
  output logic              word_stb,
  output logic              hit_stb,
  output logic              found,
  output logic [DATA_W-1:0] w_data,
  output logic              w_perr,
  output logic              w_ferr,
  output logic              w_brk,
  output logic              w_match
);
  fr_state_t         st;
  logic [DATA_W-1:0] sh, sh_next, aligned, pat;
  logic [2:0]        cnt;
  logic              last;

  assign sh_next = {bit_val, sh[DATA_W-1:1]};
  assign aligned = sh_next >> wlen;
  assign pat     = sync_char & len_mask(wlen);
  assign last    = (cnt == 3'd7 - {1'b0, wlen});
  assign hunt    = (st == FR_HUNT);
  assign busy    = (st == FR_DATA) || (st == FR_PAR) || (st == FR_STOP);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st <= fmt_sync ? FR_SEARCH : FR_HUNT;
      sh <= '0; cnt <= '0; found <= 1'b0; word_stb <= 1'b0; hit_stb <= 1'b0;
      w_data <= '0; w_perr <= 1'b0; w_ferr <= 1'b0; w_brk <= 1'b0; w_match <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      hit_stb  <= 1'b0;
      case (st)
        FR_HUNT: begin
          if (fmt_sync) st <= FR_SEARCH;
          else if (start_stb) begin st <= FR_DATA; cnt <= '0; end
        end
        FR_SEARCH: begin
          if (!fmt_sync) st <= FR_HUNT;
          else if (bit_stb) begin
            sh <= sh_next;
            if (aligned == pat) begin
              found <= 1'b1; hit_stb <= 1'b1; st <= FR_DATA; cnt <= '0;
            end
          end
        end
        FR_DATA: if (bit_stb) begin
          sh  <= sh_next;
          cnt <= cnt + 1'b1;
          if (last) begin
            w_data <= aligned; w_match <= (aligned == pat);
            w_perr <= 1'b0; w_ferr <= 1'b0; w_brk <= 1'b0;
            cnt <= '0;
            if (par_en) st <= FR_PAR;
            else if (fmt_sync) word_stb <= 1'b1;
            else st <= FR_STOP;
          end
        end
        FR_PAR: if (bit_stb) begin
          w_perr <= ^w_data ^ bit_val ^ ~par_even;
          if (fmt_sync) begin word_stb <= 1'b1; st <= FR_DATA; end
          else st <= FR_STOP;
        end
        FR_STOP: if (bit_stb) begin
          w_ferr   <= !bit_val && (w_data != '0);
          w_brk    <= !bit_val && (w_data == '0);
          word_stb <= 1'b1;
          st       <= FR_HUNT;
        end
        default: st <= FR_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/rxs_status.sv
module rxs_status
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              fmt_sync,
  input  logic              strip,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] w_data,
  input  logic              w_perr,
  input  logic              w_ferr,
  input  logic              w_brk,
  input  logic              w_match,
  input  logic              hit_stb,
  input  logic              lvl,
  input  logic              pop,
  input  logic              stat_rd,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              brk,
  output logic              ovr,
  output logic              mt,
  output logic              full_stb,
  output logic              err_stb
);
  logic ovr_pend, b_one, b_rd, drop, reveal, load_ok;

  assign drop    = strip && fmt_sync && w_match;
  assign reveal  = pop && ovr_pend;
  assign load_ok = !(full && !pop) && !ovr && !reveal;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      full <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0; brk <= 1'b0;
      ovr <= 1'b0; ovr_pend <= 1'b0; mt <= 1'b0; b_one <= 1'b0; b_rd <= 1'b0;
      full_stb <= 1'b0; err_stb <= 1'b0;
    end else begin
      full_stb <= 1'b0;
      err_stb  <= hit_stb;
      if (stat_rd) ovr <= 1'b0;
      if (pop) begin
        full <= 1'b0;
        if (ovr_pend) begin ovr <= 1'b1; ovr_pend <= 1'b0; err_stb <= 1'b1; end
      end
      if (brk) begin
        if (lvl) b_one <= 1'b1;
        if (stat_rd) b_rd <= 1'b1;
        if ((b_one || lvl) && (b_rd || stat_rd)) brk <= 1'b0;
      end
      if (word_stb) begin
        if (fmt_sync) mt <= w_match;
        if (!drop) begin
          if (load_ok) begin
            full <= 1'b1; data <= w_data; perr <= w_perr; ferr <= w_ferr;
            full_stb <= 1'b1;
            if (w_perr || w_ferr || w_brk) err_stb <= 1'b1;
            if (w_brk) begin brk <= 1'b1; b_one <= 1'b0; b_rd <= 1'b0; end
          end else if (full && !pop && !ovr) ovr_pend <= 1'b1;
        end
      end
    end
  end

  // R8: a waiting word is never replaced
  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (full && !pop) |=> $stable(data));
  // R8: overrun only surfaces right after the held word is taken
  assert_ovr_after_pop_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
    $rose(ovr) |-> $past(pop));
  // R7: flags stay frozen with the waiting word
  assert_flags_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (full && !pop) |=> ($stable(perr) && $stable(ferr)));
  // R11: a stripped sync word never fills an empty buffer
  assert_strip_R11: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (word_stb && drop && !full) |=> !full);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import rxs_pkg::*;
#(
  parameter int HALF_BIT = 8,
  parameter int FILT_EDGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_in,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_x16,
  input  logic [DATA_W-1:0] cfg_sync_char,
  input  logic              cfg_strip,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              stat_rd,
  output logic              st_overrun,
  output logic              st_parity,
  output logic              st_frame,
  output logic              st_break,
  output logic              st_found,
  output logic              st_match,
  output logic              full_stb,
  output logic              err_stb,
  output logic              dma_ready
);
  logic fmt_sync, hunt, busy, bit_stb, bit_val, start_stb, lvl;
  logic word_stb, hit_stb, w_perr, w_ferr, w_brk, w_match, mt;
  logic [DATA_W-1:0] w_data;

  assign fmt_sync = (cfg_fmt == 2'b00);

  rxs_sampler #(.HALF(HALF_BIT), .FILT(FILT_EDGES)) u_smp (
    .clk, .rst_n, .en(rx_en), .os16(cfg_x16), .hunt, .sin(rx_in),
    .bit_stb, .bit_val, .start_stb, .lvl);

  rxs_framer u_frm (
    .clk, .rst_n, .en(rx_en), .fmt_sync, .wlen(cfg_wlen), .par_en(cfg_par_en),
    .par_even(cfg_par_even), .sync_char(cfg_sync_char), .bit_stb, .bit_val,
    .start_stb, .hunt, .busy, .word_stb, .hit_stb, .found(st_found), .w_data,
    .w_perr, .w_ferr, .w_brk, .w_match);

  rxs_status u_sts (
    .clk, .rst_n, .en(rx_en), .fmt_sync, .strip(cfg_strip), .word_stb, .w_data,
    .w_perr, .w_ferr, .w_brk, .w_match, .hit_stb, .lvl,
    .pop(rd_valid && rd_ready), .stat_rd, .full(rd_valid), .data(rd_data),
    .perr(st_parity), .ferr(st_frame), .brk(st_break), .ovr(st_overrun), .mt,
    .full_stb, .err_stb);

  assign st_match  = fmt_sync ? mt : busy;
  assign dma_ready = rd_valid && !st_parity && !st_frame;

  // R13: disabling empties the buffer and drops every status
  assert_disable_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rd_valid && !st_found && !st_overrun && !st_break));
endmodule

// File: tb/tb_serial_rx_core.sv
`timescale 1ns/1ps
module tb_serial_rx_core;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, rx_in = 1'b1;
  logic [1:0] cfg_wlen = 2'd0, cfg_fmt = 2'd1;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_x16 = 1'b0, cfg_strip = 1'b0;
  logic [7:0] cfg_sync_char = 8'h96;
  logic rd_ready = 1'b0, stat_rd = 1'b0;
  logic rd_valid, st_overrun, st_parity, st_frame, st_break, st_found, st_match;
  logic full_stb, err_stb, dma_ready;
  logic [7:0] rd_data;
  int checks = 0, fails = 0, errs = 0;

  always #2.5 clk = ~clk;

  serial_rx_core dut (.*);

  always @(posedge clk) if (err_stb) errs++;

  // {x16, wlen, par_en, par_even, corrupt, data}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 8'hC3},
    {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 8'h3F},
    {1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 8'h1F},
    {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'h5A},
    {1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'h7E},
    {1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'hFF},
    {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'h80}
  };

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b, input int cyc);
    rx_in = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [7:0] d, input logic hp, input logic pb,
                      input logic sb, input int per);
    drive_bit(1'b0, per);
    for (int i = 0; i < n; i++) drive_bit(d[i], per);
    if (hp) drive_bit(pb, per);
    drive_bit(sb, per);
    drive_bit(1'b1, (per > 1) ? 48 : 6);
  endtask

  task automatic pop();
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic sread();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R7 reset rd_valid", rd_valid, 0);
    chk("R9 reset dma_ready", dma_ready, 0);
    chk("R13 reset flags", {st_overrun, st_parity, st_frame, st_break, st_found}, 0);
    rst_n = 1'b1; rx_en = 1'b1;
    drive_bit(1'b1, 40);

    // table walk: R1 lengths, R2 x1 sampling, R3/R4 x16 framing, R5 parity, R9 ready
    for (int k = 0; k < 8; k++) begin
      logic [7:0] msk, d;
      logic p;
      int n;
      cfg_x16 = VEC[k][13]; cfg_wlen = VEC[k][12:11];
      cfg_par_en = VEC[k][10]; cfg_par_even = VEC[k][9];
      n = 8 - int'(VEC[k][12:11]);
      msk = 8'hFF >> VEC[k][12:11];
      d = VEC[k][7:0] & msk;
      p = (^d) ^ ~VEC[k][9] ^ VEC[k][8];
      drive_bit(1'b1, 40);
      send(n, d, VEC[k][10], p, 1'b1, VEC[k][13] ? 16 : 1);
      chk($sformatf("R1 R2 R3 vec%0d valid", k), rd_valid, 1);
      chk($sformatf("R1 vec%0d data", k), rd_data, d);
      chk($sformatf("R5 vec%0d parity", k), st_parity, VEC[k][8]);
      chk($sformatf("R9 vec%0d ready", k), dma_ready, !VEC[k][8]);
      pop();
      chk($sformatf("R7 vec%0d taken", k), rd_valid, 0);
    end

    // R4: drifting 15-clock bits with transitions every bit
    cfg_x16 = 1'b1; cfg_wlen = 2'd0; cfg_par_en = 1'b0;
    drive_bit(1'b1, 40);
    send(8, 8'h55, 1'b0, 1'b0, 1'b1, 15);
    chk("R4 resync data", rd_data, 8'h55);
    chk("R4 resync valid", rd_valid, 1);
    pop();

    // R3: short low pulses are rejected
    drive_bit(1'b0, 5); drive_bit(1'b1, 60);
    drive_bit(1'b0, 2); drive_bit(1'b1, 60);
    chk("R3 false start no word", rd_valid, 0);
    chk("R3 false start idle", st_match, 0);

    // R12: character in progress in start/stop framing
    fork
      send(8, 8'h33, 1'b0, 1'b0, 1'b1, 16);
      begin repeat (60) @(negedge clk); chk("R12 char in progress", st_match, 1); end
    join
    chk("R12 idle after char", st_match, 0);
    pop();

    // R8 overrun sequence in x1
    cfg_x16 = 1'b0;
    drive_bit(1'b1, 10);
    send(8, 8'h11, 1'b0, 1'b0, 1'b1, 1);
    send(8, 8'h22, 1'b0, 1'b0, 1'b1, 1);
    chk("R8 held word kept", rd_data, 8'h11);
    chk("R8 overrun hidden", st_overrun, 0);
    errs = 0;
    pop(); @(negedge clk);
    chk("R8 overrun after take", st_overrun, 1);
    chk("R8 overrun err strobe", errs, 1);
    send(8, 8'h33, 1'b0, 1'b0, 1'b1, 1);
    chk("R8 stalled drop", rd_valid, 0);
    sread();
    chk("R8 cleared by status read", st_overrun, 0);
    send(8, 8'h44, 1'b0, 1'b0, 1'b1, 1);
    chk("R8 resumes", rd_data, 8'h44);
    pop();

    // R6 frame error and break
    send(8, 8'h5A, 1'b0, 1'b0, 1'b0, 1);
    chk("R6 frame flag", st_frame, 1);
    chk("R9 frame blocks ready", dma_ready, 0);
    pop();
    send(8, 8'h00, 1'b0, 1'b0, 1'b0, 1);
    chk("R6 break flag", st_break, 1);
    chk("R6 break not frame", st_frame, 0);
    pop(); drive_bit(1'b1, 5);
    chk("R6 break held until read", st_break, 1);
    sread(); @(negedge clk);
    chk("R6 break released", st_break, 0);

    // R10/R11 sync hunt with stripping
    rx_en = 1'b0; @(negedge clk);
    cfg_fmt = 2'd0; cfg_strip = 1'b1; cfg_sync_char = 8'h96;
    rx_en = 1'b1;
    drive_bit(1'b1, 10);
    chk("R10 not found while hunting", st_found, 0);
    errs = 0;
    for (int i = 0; i < 8; i++) drive_bit(cfg_sync_char[i], 1);
    for (int i = 0; i < 8; i++) drive_bit(8'h3C >> i, 1);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        chk("R10 framed word", rd_data, 8'h3C);
        rd_ready = 1'b1;
      end
      if (i == 4) rd_ready = 1'b0;
      drive_bit(cfg_sync_char[i], 1);
    end
    repeat (3) @(negedge clk);
    chk("R10 found", st_found, 1);
    chk("R10 hit strobe", errs, 1);
    chk("R11 stripped", rd_valid, 0);
    chk("R12 sync match", st_match, 1);

    // R13 disable
    rx_en = 1'b0; repeat (2) @(negedge clk);
    chk("R13 found cleared", st_found, 0);
    chk("R13 buffer cleared", rd_valid, 0);
    report();
  end
endmodule